// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a register-driven master for the two-wire PHY management bus (MDC clock, bidirectional MDIO data). Software packs a complete management frame into one 32-bit word and writes it to the frame register. That single write starts the transfer. The controller sends a run of ones as the preamble, then shifts out the frame word with its most significant bit first. For a read frame it releases the data line during the turnaround and the data bits. It collects the 16 bits that the PHY returns and places them in the low half of the same frame register.

At the end of every frame a completion event bit is set in an event register. Software clears this bit by writing a one to it. An interrupt output follows the event bit whenever the matching bit in a mask register is set. A speed field sets the MDC rate: each MDC phase lasts that many system clocks. Only one frame can be in flight at a time. A frame write that arrives while the controller is busy is dropped.

Frame word layout: bits 31:30 hold the start pattern (01), bits 29:28 the opcode (01 = write, 10 = read), bits 27:23 the PHY address, bits 22:18 the register address, bits 17:16 the turnaround (10) and bits 15:0 the data. Software supplies every field. The controller decodes only the opcode.

Register indices on `bus_addr`: 0 = frame, 1 = event, 2 = mask, 3 = speed, 4 = status. All other indices read as zero.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: When the controller is idle, a write to register index 0 stores the word and starts a frame. Status register bit 0 (busy) reads 1 from the cycle after that write until the frame ends, and reads 0 when idle.
- R2: Each frame gives exactly 64 MDC rising edges. At those edges MDIO carries 32 ones first, then frame word bits 31 down to 0. MDIO never changes while MDC is high.
- R3: MDC stays high for S system clocks and low for S system clocks, where S is the value in bits SPEED_W:1 of register index 3. S = 0 behaves as S = 1. The field reads back at the same bit positions. MDC is low while idle.
- R4: For a read frame (opcode bits 29:28 = 10), the MDIO output enable is low at MDC rising edges 46 to 63, which cover the turnaround and the data. At every other rising edge of any frame the enable is high. The enable is low while idle (default variant).
- R5: For a read frame, MDIO input is sampled on MDC rising edges 48 to 63, first bit into bit 15. At completion the sampled value replaces frame register bits 15:0, and bits 31:16 keep the written value. A write frame leaves the register as written.
- R6: When a frame completes, bit EVT_POS of the event register (index 1, default bit 23) is set.
- R7: Writing 1 to bit EVT_POS of the event register clears the event. Writing 0 there leaves it unchanged. Writing all ones clears it.
- R8: `irq` is high exactly when the event bit is set and bit EVT_POS of the mask register (index 2) is 1. A mask of zero holds `irq` low.
- R9: A write to register index 0 while busy is ignored. The register contents and the frame on the wire stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| irq | output | 1 | Masked completion interrupt |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench records MDIO and the output enable at every MDC rising edge. It compares that record with the preamble and the frame word. A shifter that is off by one bit, or one that drops the preamble, therefore shows as a wrong bit string or a wrong edge count. A PHY responder returns a known pattern on read frames. An engine that samples one edge early or late, releases the line at the wrong edge, or overwrites the upper fields of the register would store a different value. The bench also times the MDC edges at several speed settings, including zero, so a divider that is off by one, or that stalls at zero, is caught. Further tests write a new frame in the middle of a transfer and write zero, one and all ones to the event register. These catch a controller that accepts a write while busy or a clear that acts on the wrong bit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam int unsigned ADDR_W = 3;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned DATA_W = 16;

   localparam logic [ADDR_W-1:0] IDX_FRAME  = 3'd0;
   localparam logic [ADDR_W-1:0] IDX_EVENT  = 3'd1;
   localparam logic [ADDR_W-1:0] IDX_MASK   = 3'd2;
   localparam logic [ADDR_W-1:0] IDX_SPEED  = 3'd3;
   localparam logic [ADDR_W-1:0] IDX_STATUS = 3'd4;

   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;

   // position of the opcode inside the frame word
   localparam int unsigned OPC_LSB = 28;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] half_len,
   output logic             phase_end
);
   logic [CNT_W-1:0] cnt_q;

   assign phase_end = run && (cnt_q == (half_len - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || phase_end)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_pkg::*;
#(
   parameter int unsigned PRE_BITS = 32,
   parameter int unsigned CNT_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] frame_in,
   input  logic [CNT_W-1:0]  half_len,
   input  logic              mdio_i,
   output logic              busy,
   output logic              done,
   output logic              mdc,
   output logic              mdio_o,
   output logic              drive_en,
   output logic              is_read,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned TOTAL = PRE_BITS + WORD_W;
   localparam int unsigned IDX_W = $clog2(TOTAL);
   localparam logic [IDX_W-1:0] PRE_END  = IDX_W'(PRE_BITS);
   localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_BITS + WORD_W - DATA_W - 2);
   localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_BITS + WORD_W - DATA_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

   generate
      if (PRE_BITS < 1 || PRE_BITS > 64) begin : g_bad_pre
         $error("mdio_frame_engine: PRE_BITS must be 1..64");
      end
   endgenerate

   logic              busy_q;
   logic              mdc_q;
   logic              rd_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WORD_W-1:0] sh_q;
   logic [DATA_W-1:0] cap_q;
   logic              phase_end;

   mdio_half_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy_q),
      .half_len  (half_len),
      .phase_end (phase_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         mdc_q  <= 1'b0;
         rd_q   <= 1'b0;
         idx_q  <= '0;
         sh_q   <= '0;
         cap_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         mdc_q  <= 1'b0;
         idx_q  <= '0;
         sh_q   <= frame_in;
         rd_q   <= (frame_in[OPC_LSB+1:OPC_LSB] == OPC_READ);
         cap_q  <= '0;
      end else if (busy_q && phase_end) begin
         if (!mdc_q) begin
            // rising MDC: the PHY side has held its bit for a full low phase
            mdc_q <= 1'b1;
            if (rd_q && idx_q >= DAT_IDX)
               cap_q <= {cap_q[DATA_W-2:0], mdio_i};
         end else begin
            // falling MDC: step to the next bit or finish
            mdc_q <= 1'b0;
            if (idx_q == LAST_IDX) begin
               busy_q <= 1'b0;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
               if (idx_q >= PRE_END)
                  sh_q <= {sh_q[WORD_W-2:0], 1'b0};
            end
         end
      end
   end

   assign busy     = busy_q;
   assign mdc      = mdc_q;
   assign done     = busy_q && phase_end && mdc_q && (idx_q == LAST_IDX);
   assign mdio_o   = (busy_q && idx_q >= PRE_END) ? sh_q[WORD_W-1] : 1'b1;
   assign drive_en = !(rd_q && idx_q >= TA_IDX);
   assign is_read  = rd_q;
   assign rd_data  = cap_q;
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
   import mdio_pkg::*;
#(
   parameter int unsigned SPEED_W   = 6,
   parameter int unsigned EVT_POS   = 23,
   parameter int unsigned SPEED_RST = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [WORD_W-1:0]  bus_wdata,
   output logic [WORD_W-1:0]  bus_rdata,
   input  logic               busy,
   input  logic               done,
   input  logic               is_read,
   input  logic [DATA_W-1:0]  rd_data,
   output logic               start,
   output logic [WORD_W-1:0]  frame_q,
   output logic [SPEED_W-1:0] half_len,
   output logic               evt_q,
   output logic               mask_q,
   output logic               irq
);
   generate
      if (SPEED_W < 1 || SPEED_W > WORD_W - 2) begin : g_bad_speed
         $error("mdio_csr: SPEED_W out of range");
      end
      if (EVT_POS >= WORD_W) begin : g_bad_evt
         $error("mdio_csr: EVT_POS out of range");
      end
      if (SPEED_RST >= (1 << SPEED_W)) begin : g_bad_rst
         $error("mdio_csr: SPEED_RST does not fit");
      end
   endgenerate

   logic [SPEED_W-1:0] spd_q;
   logic wr_frame, wr_event, wr_mask, wr_speed;

   assign wr_frame = bus_wr && (bus_addr == IDX_FRAME);
   assign wr_event = bus_wr && (bus_addr == IDX_EVENT);
   assign wr_mask  = bus_wr && (bus_addr == IDX_MASK);
   assign wr_speed = bus_wr && (bus_addr == IDX_SPEED);
   assign start    = wr_frame && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_q <= '0;
         spd_q   <= SPEED_W'(SPEED_RST);
         evt_q   <= 1'b0;
         mask_q  <= 1'b0;
      end else begin
         if (start)
            frame_q <= bus_wdata;
         else if (done && is_read)
            frame_q[DATA_W-1:0] <= rd_data;

         if (done)
            evt_q <= 1'b1;
         else if (wr_event && bus_wdata[EVT_POS])
            evt_q <= 1'b0;

         if (wr_mask)
            mask_q <= bus_wdata[EVT_POS];
         if (wr_speed)
            spd_q <= bus_wdata[SPEED_W:1];
      end
   end

   assign half_len = (spd_q == '0) ? SPEED_W'(1) : spd_q;
   assign irq      = evt_q & mask_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         IDX_FRAME:  bus_rdata = frame_q;
         IDX_EVENT:  bus_rdata[EVT_POS] = evt_q;
         IDX_MASK:   bus_rdata[EVT_POS] = mask_q;
         IDX_SPEED:  bus_rdata[SPEED_W:1] = spd_q;
         IDX_STATUS: bus_rdata[0] = busy;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
   import mdio_pkg::*;
#(
   parameter int unsigned SPEED_W    = 6,
   parameter int unsigned EVT_POS    = 23,
   parameter int unsigned SPEED_RST  = 0,
   parameter int unsigned PRE_BITS   = 32,
   parameter bit          IDLE_DRIVE = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [2:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   logic               eng_busy;
   logic               eng_done;
   logic               eng_drive;
   logic               eng_rd;
   logic [DATA_W-1:0]  eng_rdata;
   logic               start;
   logic [WORD_W-1:0]  frame_q;
   logic [SPEED_W-1:0] half_len;
   logic               evt_q;
   logic               mask_q;

   mdio_csr #(
      .SPEED_W   (SPEED_W),
      .EVT_POS   (EVT_POS),
      .SPEED_RST (SPEED_RST)
   ) u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .busy      (eng_busy),
      .done      (eng_done),
      .is_read   (eng_rd),
      .rd_data   (eng_rdata),
      .start     (start),
      .frame_q   (frame_q),
      .half_len  (half_len),
      .evt_q     (evt_q),
      .mask_q    (mask_q),
      .irq       (irq)
   );

   mdio_frame_engine #(
      .PRE_BITS (PRE_BITS),
      .CNT_W    (SPEED_W)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .frame_in (bus_wdata),
      .half_len (half_len),
      .mdio_i   (mdio_i),
      .busy     (eng_busy),
      .done     (eng_done),
      .mdc      (mdc),
      .mdio_o   (mdio_o),
      .drive_en (eng_drive),
      .is_read  (eng_rd),
      .rd_data  (eng_rdata)
   );

   generate
      if (IDLE_DRIVE) begin : g_idle_drive
         assign mdio_oe = eng_busy ? eng_drive : 1'b1;
      end else begin : g_idle_release
         assign mdio_oe = eng_busy && eng_drive;
      end
   endgenerate
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk #(
   parameter bit IDLE_DRIVE = 1'b0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe,
   input logic        irq,
   input logic        evt,
   input logic        mask,
   input logic [31:0] frame_q
);
   p_mdc_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   p_oe_idle_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!IDLE_DRIVE && !busy) |-> !mdio_oe);

   p_data_steady_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> $stable(mdio_o));

   p_done_sets_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> evt);

   p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mask && evt));

   p_frame_held_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(frame_q));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk #(.IDLE_DRIVE(IDLE_DRIVE)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (eng_busy),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe),
   .irq     (irq),
   .evt     (evt_q),
   .mask    (mask_q),
   .frame_q (frame_q)
);

// File: tb/mdio_mgmt_ctrl_test.sv
module mdio_mgmt_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] EVT_BIT = 32'h0080_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int rise_cnt = 0;
   int fall_cnt = 0;
   int t_r0 = 0, t_r1 = 0, t_f0 = 0;
   logic [63:0] rec_o, rec_oe;
   logic [15:0] resp = 16'h0000;

   mdio_mgmt_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc++;

   // recorder and PHY responder
   always @(posedge mdc) begin
      if (rise_cnt < 64) begin
         rec_o[63-rise_cnt]  = mdio_o;
         rec_oe[63-rise_cnt] = mdio_oe;
      end
      if (rise_cnt == 0) t_r0 = cyc;
      if (rise_cnt == 1) t_r1 = cyc;
      rise_cnt++;
   end
   always @(negedge mdc) begin
      if (fall_cnt == 0) t_f0 = cyc;
      fall_cnt++;
      if (rise_cnt >= 48 && rise_cnt <= 63) mdio_i = resp[63-rise_cnt];
      else mdio_i = 1'b1;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic arm;
      rise_cnt = 0; fall_cnt = 0; rec_o = '0; rec_oe = '0;
   endtask

   task automatic wait_idle;
      logic [31:0] s;
      bit ok = 1'b0;
      for (int i = 0; i < 5000; i++) begin
         bus_read(3'd4, s);
         if (s[0] == 1'b0) begin ok = 1'b1; break; end
      end
      chk(ok, "R1 frame finishes", {63'd0, ok}, 64'd1);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      bus_read(3'd0, v); chk(v == 0, "R5 reset frame reg", v, 0);
      bus_read(3'd1, v); chk(v == 0, "R6 reset event", v, 0);
      bus_read(3'd4, v); chk(v == 0, "R1 reset busy", v, 0);
      chk(!mdc && !mdio_oe && !irq, "R3 R4 R8 reset pins", {mdc, mdio_oe, irq}, 0);
   endtask

   task automatic t_write_frame;
      logic [31:0] w = {2'b01, 2'b01, 5'h05, 5'h11, 2'b10, 16'hA5C3};
      logic [31:0] v;
      arm();
      bus_write(3'd0, w);
      repeat (3) @(negedge clk);
      bus_read(3'd4, v); chk(v[0] == 1'b1, "R1 busy during frame", v, 1);
      wait_idle();
      chk(rise_cnt == 64, "R2 edge count", rise_cnt, 64);
      chk(rec_o == {32'hFFFF_FFFF, w}, "R2 write bits", rec_o, {32'hFFFF_FFFF, w});
      chk(rec_oe == '1, "R4 write drives all", rec_oe, '1);
      chk(t_r1 - t_r0 == 2, "R3 period speed 0", t_r1 - t_r0, 2);
      bus_read(3'd0, v); chk(v == w, "R5 write keeps word", v, w);
      bus_read(3'd1, v); chk(v == EVT_BIT, "R6 event set", v, EVT_BIT);
      chk(!irq, "R8 masked irq", irq, 0);
      chk(!mdc && !mdio_oe, "R3 R4 idle pins", {mdc, mdio_oe}, 0);
   endtask

   task automatic t_event_clear;
      logic [31:0] v;
      bus_write(3'd1, 32'h0000_0000);
      bus_read(3'd1, v); chk(v == EVT_BIT, "R7 zero write no effect", v, EVT_BIT);
      bus_write(3'd1, ~EVT_BIT);
      bus_read(3'd1, v); chk(v == EVT_BIT, "R7 other bits no effect", v, EVT_BIT);
      bus_write(3'd2, EVT_BIT);
      @(negedge clk); chk(irq, "R8 unmasked irq", irq, 1);
      bus_write(3'd2, 32'h0);
      @(negedge clk); chk(!irq, "R8 mask zero", irq, 0);
      bus_write(3'd1, EVT_BIT);
      bus_read(3'd1, v); chk(v == 0, "R7 w1c clears", v, 0);
   endtask

   task automatic t_read_frame;
      logic [31:0] w = {2'b01, 2'b10, 5'h1F, 5'h0A, 2'b10, 16'h1234};
      logic [31:0] v;
      resp = 16'h3C96;
      bus_write(3'd2, EVT_BIT);
      arm();
      bus_write(3'd0, w);
      wait_idle();
      chk(rec_oe == {{46{1'b1}}, {18{1'b0}}}, "R4 release window", rec_oe, {{46{1'b1}}, {18{1'b0}}});
      chk(rec_o[63:18] == {32'hFFFF_FFFF, w[31:18]}, "R2 read header bits", rec_o[63:18], {32'hFFFF_FFFF, w[31:18]});
      bus_read(3'd0, v); chk(v == {w[31:16], resp}, "R5 captured data", v, {w[31:16], resp});
      chk(irq, "R8 R6 irq on read done", irq, 1);
      bus_write(3'd1, 32'hFFFF_FFFF);
      bus_read(3'd1, v); chk(v == 0 && !irq, "R7 all ones clear", {v, irq}, 0);
      bus_write(3'd2, 32'h0);
   endtask

   task automatic t_busy_ignore;
      logic [31:0] a = {2'b01, 2'b01, 5'h02, 5'h03, 2'b10, 16'h0F0F};
      logic [31:0] b = {2'b01, 2'b10, 5'h1C, 5'h1D, 2'b10, 16'hFFFF};
      logic [31:0] v;
      arm();
      bus_write(3'd0, a);
      repeat (10) @(negedge clk);
      bus_write(3'd0, b);
      bus_read(3'd0, v); chk(v == a, "R9 register unchanged", v, a);
      wait_idle();
      chk(rec_o == {32'hFFFF_FFFF, a}, "R9 wire unchanged", rec_o, {32'hFFFF_FFFF, a});
      chk(rise_cnt == 64, "R9 single frame", rise_cnt, 64);
      bus_write(3'd1, EVT_BIT);
   endtask

   task automatic t_speed;
      logic [31:0] w = {2'b01, 2'b01, 5'h01, 5'h01, 2'b10, 16'h8001};
      logic [31:0] v;
      bus_write(3'd3, 32'd3 << 1);
      bus_read(3'd3, v); chk(v == 32'd6, "R3 speed readback", v, 6);
      arm();
      bus_write(3'd0, w);
      wait_idle();
      chk(t_r1 - t_r0 == 6, "R3 period speed 3", t_r1 - t_r0, 6);
      chk(t_f0 - t_r0 == 3, "R3 high time speed 3", t_f0 - t_r0, 3);
      chk(rec_o == {32'hFFFF_FFFF, w}, "R2 bits at speed 3", rec_o, {32'hFFFF_FFFF, w});
      bus_write(3'd3, 32'd1 << 1);
      arm();
      bus_write(3'd0, w);
      wait_idle();
      chk(t_r1 - t_r0 == 2, "R3 period speed 1", t_r1 - t_r0, 2);
      bus_write(3'd1, EVT_BIT);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_frame();
      t_event_clear();
      t_read_frame();
      t_busy_ignore();
      t_speed();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule